// File: doc/BRIEF.md
# Serial Tank Clear and End-Pulse Controller

This block sequences the clearing of the three arithmetic registers of a serial, recirculating arithmetic unit: the accumulator, the multiplier register and the multiplicand register. It also produces completion pulses for the two store instructions. A request is first captured in an arming flag. The flag is passed to a hold flag at the next odd-cycle digit-zero strobe. The hold flag drops at the next even-cycle digit-zero strobe. While the hold flag is set, each register's active-low clear is gated by that register's own timing pulse. The multiplicand clear follows the hold flag directly.

The plain store instruction ends with a single-cycle pulse taken from the first even-cycle strobe after its request. The store-and-clear instruction needs extra time to empty the accumulator. It therefore ends with a separate pulse, generated by a counter-based monostable that fires when the accumulator-clear gate falls. A load-multiplier request drives the clears and produces no completion pulse. Every pin is a plain level or strobe, and none carries a data stream, so there is no valid/ready interface and no back-pressure.

Top module: `tank_clear_ctrl`

## Requirements
- R1: The arming flag is set at the clock edge after a cycle in which either `op_store` or `op_store_clr` is high together with `xfer_done`, or `op_load_mplr` is high. A store request with `xfer_done` low sets nothing.
- R2: At an edge where `digit0_odd` is high, the arming flag's value is copied into the hold flag and the arming flag clears, unless a new request arrives in that same cycle. A later odd strobe with no new request leaves the hold flag clear.
- R3: The hold flag stays set until the edge of a cycle with `digit0_even` high and `digit0_odd` low, and it is clear from the following cycle on.
- R4: `mcand_clr_n` is low exactly while the hold flag is set, whatever the request type.
- R5: `acc_clr_n` is low only in cycles where the hold flag is set and `tp_acc` is high. `mplr_clr_n` is low only in cycles where the hold flag is set and `tp_mplr` is high. Both are combinational from the timing pulse.
- R6: `store_end` is high for exactly one cycle: the cycle after the first `digit0_even` strobe that follows a plain store request. This holds even when that strobe comes before the odd handoff. The hold window's own later even strobe gives no second pulse.
- R7: For a store-and-clear request, the cycle in which the accumulator-clear gate (hold flag AND `tp_acc`) goes from high to low starts the monostable. `store_clr_end` is then high for one cycle, DELAY+1 cycles after that cycle.
- R8: A falling accumulator-clear gate that arrives while the monostable is counting is ignored. After the pulse, the monostable can be started again.
- R9: Plain store never produces `store_clr_end`. Store-and-clear never produces `store_end`. Load-multiplier produces neither pulse.
- R10: A synchronous `rst` returns every flag, the pending store and the monostable to idle. All three clears go high and both pulses go low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| digit0_odd | input | 1 | Digit-zero strobe of an odd cycle |
| digit0_even | input | 1 | Digit-zero strobe of an even cycle |
| tp_acc | input | 1 | Timing pulse qualifying the accumulator clear |
| tp_mplr | input | 1 | Timing pulse qualifying the multiplier clear |
| op_store | input | 1 | Plain store instruction decoded |
| op_store_clr | input | 1 | Store-and-clear instruction decoded |
| xfer_done | input | 1 | Store transfer to memory has completed |
| op_load_mplr | input | 1 | Load-multiplier instruction about to run |
| acc_clr_n | output | 1 | Accumulator clear, active low |
| mplr_clr_n | output | 1 | Multiplier register clear, active low |
| mcand_clr_n | output | 1 | Multiplicand register clear, active low |
| store_end | output | 1 | One-cycle completion pulse for plain store |
| store_clr_end | output | 1 | One-cycle completion pulse for store-and-clear |

## Verification
The hardest case to reach from the ports is a second falling accumulator-clear gate that arrives while the monostable is still counting. The bench creates it by issuing a second store-and-clear request, odd strobe and `tp_acc` burst within the DELAY window of the first. It then counts pulses over the whole span, expecting exactly one, and later starts the monostable again after it expires. A related case is an even strobe that comes before the odd handoff. The bench drives a store request, follows it at once with an even strobe, and checks that the end pulse comes from that early strobe and not from the hold window's own even strobe.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  // Request type remembered from capture to the end of the hold window
  typedef enum logic [1:0] {
    OP_NONE      = 2'd0,
    OP_STORE     = 2'd1,
    OP_STORE_CLR = 2'd2,
    OP_LOAD_MPLR = 2'd3
  } op_kind_e;

  // Number of clears gated by their own timing pulse (accumulator, multiplier)
  localparam int unsigned NUM_GATED = 2;
  localparam int unsigned GATE_ACC  = 0;
  localparam int unsigned GATE_MPLR = 1;
endpackage

// File: rtl/tcc_flag_pipe.sv
module tcc_flag_pipe
  import tcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req,
  input  op_kind_e req_kind,
  input  logic     digit0_odd,
  input  logic     digit0_even,
  output logic     held,
  output op_kind_e held_kind
);
  logic     armed;
  op_kind_e armed_kind;

  // Arming stage: a new request wins over the handoff release
  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      armed_kind <= OP_NONE;
    end else if (req) begin
      armed      <= 1'b1;
      armed_kind <= req_kind;
    end else if (digit0_odd) begin
      armed      <= 1'b0;
      armed_kind <= OP_NONE;
    end
  end

  // Hold stage: the odd strobe copies, the even strobe releases (odd has priority)
  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= 1'b0;
      held_kind <= OP_NONE;
    end else if (digit0_odd) begin
      held      <= armed;
      held_kind <= armed_kind;
    end else if (digit0_even) begin
      held      <= 1'b0;
      held_kind <= OP_NONE;
    end
  end

  p_handoff_r2: assert property (@(posedge clk) disable iff (rst)
    (digit0_odd && armed) |=> held);

  p_arm_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (digit0_odd && !req) |=> !armed);

  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    (digit0_even && !digit0_odd) |=> !held);
endmodule

// File: rtl/tcc_clear_gates.sv
module tcc_clear_gates #(
  parameter int unsigned NG = 2
) (
  input  logic          hold,
  input  logic [NG-1:0] tp,
  output logic [NG-1:0] gated_n,
  output logic          whole_n
);
  // One gate per timed register clear
  for (genvar gi = 0; gi < NG; gi++) begin : g_gate
    assign gated_n[gi] = ~(hold & tp[gi]);
  end

  // Multiplicand clear follows the hold flag for the whole window
  assign whole_n = ~hold;
endmodule

// File: rtl/tcc_store_end.sv
module tcc_store_end
  import tcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req,
  input  op_kind_e req_kind,
  input  logic     digit0_even,
  output logic     pulse
);
  logic pending;
  logic new_store;

  assign new_store = req && (req_kind == OP_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      pulse   <= digit0_even && pending;
      pending <= new_store || (pending && !digit0_even);
    end
  end

  p_pulse_src_r6: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(digit0_even));

  p_pulse_once_r6: assert property (@(posedge clk) disable iff (rst)
    (pulse && !$past(new_store)) |-> !pending);
endmodule

// File: rtl/tcc_oneshot.sv
module tcc_oneshot #(
  parameter int unsigned DELAY = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;
  logic          busy;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= (cnt == ONE);
      if (busy)      cnt <= cnt - ONE;
      else if (trig) cnt <= LOAD;
    end
  end

  p_start_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && trig) |=> (cnt == LOAD));

  p_width_r7: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && trig) |=> (cnt == CW'($past(cnt) - ONE)));
endmodule

// File: rtl/tank_clear_ctrl.sv
module tank_clear_ctrl
  import tcc_pkg::*;
#(
  parameter int unsigned DELAY = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic digit0_odd,
  input  logic digit0_even,
  input  logic tp_acc,
  input  logic tp_mplr,
  input  logic op_store,
  input  logic op_store_clr,
  input  logic xfer_done,
  input  logic op_load_mplr,
  output logic acc_clr_n,
  output logic mplr_clr_n,
  output logic mcand_clr_n,
  output logic store_end,
  output logic store_clr_end
);
  logic           req;
  op_kind_e       req_kind;
  logic           hold;
  op_kind_e       hold_kind;
  logic [NUM_GATED-1:0] tp_vec;
  logic [NUM_GATED-1:0] gated_n;
  logic           sc_gate;
  logic           sc_gate_q;
  logic           sc_fall;

  // Request capture: store-and-clear over plain store over load-multiplier
  always_comb begin
    req      = 1'b1;
    req_kind = OP_NONE;
    if (op_store_clr && xfer_done)  req_kind = OP_STORE_CLR;
    else if (op_store && xfer_done) req_kind = OP_STORE;
    else if (op_load_mplr)          req_kind = OP_LOAD_MPLR;
    else                            req      = 1'b0;
  end

  tcc_flag_pipe u_flags (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .req_kind    (req_kind),
    .digit0_odd  (digit0_odd),
    .digit0_even (digit0_even),
    .held        (hold),
    .held_kind   (hold_kind)
  );

  always_comb begin
    tp_vec            = '0;
    tp_vec[GATE_ACC]  = tp_acc;
    tp_vec[GATE_MPLR] = tp_mplr;
  end

  tcc_clear_gates #(.NG(NUM_GATED)) u_gates (
    .hold    (hold),
    .tp      (tp_vec),
    .gated_n (gated_n),
    .whole_n (mcand_clr_n)
  );

  assign acc_clr_n  = gated_n[GATE_ACC];
  assign mplr_clr_n = gated_n[GATE_MPLR];

  tcc_store_end u_store_end (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .req_kind    (req_kind),
    .digit0_even (digit0_even),
    .pulse       (store_end)
  );

  // Trailing edge of the accumulator-clear gate, store-and-clear windows only
  assign sc_gate = !acc_clr_n && (hold_kind == OP_STORE_CLR);

  always_ff @(posedge clk) begin
    if (rst) sc_gate_q <= 1'b0;
    else     sc_gate_q <= sc_gate;
  end

  assign sc_fall = sc_gate_q && !sc_gate;

  tcc_oneshot #(.DELAY(DELAY)) u_mono (
    .clk   (clk),
    .rst   (rst),
    .trig  (sc_fall),
    .pulse (store_clr_end)
  );

  p_mcand_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(mcand_clr_n) |-> $past(digit0_odd));

  p_acc_in_window_r5: assert property (@(posedge clk) disable iff (rst)
    !acc_clr_n |-> (!mcand_clr_n && tp_acc));

  p_mplr_in_window_r5: assert property (@(posedge clk) disable iff (rst)
    !mplr_clr_n |-> (!mcand_clr_n && tp_mplr));

  p_idle_after_reset_r10: assert property (@(posedge clk)
    rst |=> (mcand_clr_n && acc_clr_n && mplr_clr_n && !store_end && !store_clr_end));
endmodule

// File: tb/test_tank_clear_ctrl.sv
`timescale 1ns/1ps
module test_tank_clear_ctrl;
  localparam int DLY = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic digit0_odd = 0, digit0_even = 0, tp_acc = 0, tp_mplr = 0;
  logic op_store = 0, op_store_clr = 0, xfer_done = 0, op_load_mplr = 0;
  logic acc_clr_n, mplr_clr_n, mcand_clr_n, store_end, store_clr_end;

  int n_chk = 0;
  int n_bad = 0;
  int n_st  = 0;
  int n_sc  = 0;

  always #4 clk = ~clk;

  tank_clear_ctrl #(.DELAY(DLY)) i_tank_clear_ctrl (
    .clk, .rst, .digit0_odd, .digit0_even, .tp_acc, .tp_mplr,
    .op_store, .op_store_clr, .xfer_done, .op_load_mplr,
    .acc_clr_n, .mplr_clr_n, .mcand_clr_n, .store_end, .store_clr_end
  );

  // Pulse counters, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (store_end)     n_st++;
      if (store_clr_end) n_sc++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock cycle: inputs set 2 ns after the edge, outputs sampled 6 ns after it
  task automatic cyc(input logic r, input logic od, input logic ev,
                     input logic ta, input logic tm, input logic st,
                     input logic sc, input logic xd, input logic lm);
    @(posedge clk);
    #2;
    rst = r; digit0_odd = od; digit0_even = ev; tp_acc = ta; tp_mplr = tm;
    op_store = st; op_store_clr = sc; xfer_done = xd; op_load_mplr = lm;
    #4;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0,0,0,0,0,0,0,0,0);
  endtask

  task automatic t_reset;
    cyc(1,0,0,0,0,0,0,0,0);
    cyc(1,0,0,0,0,0,0,0,0);
    chk("R10 mcand idle", mcand_clr_n, 1);
    chk("R10 acc idle",   acc_clr_n, 1);
    chk("R10 mplr idle",  mplr_clr_n, 1);
    chk("R10 st pulse",   store_end, 0);
    chk("R10 sc pulse",   store_clr_end, 0);
    cyc(0,0,0,0,0,0,0,0,0);
  endtask

  task automatic t_load_mplr;
    int s0 = n_st, c0 = n_sc;
    cyc(0,0,0,0,0,0,0,0,1);                 // request
    cyc(0,0,0,0,0,0,0,0,0);
    chk("R1 armed only, no clear yet", mcand_clr_n, 1);
    cyc(0,1,0,0,0,0,0,0,0);                 // odd handoff
    cyc(0,0,0,0,1,0,0,0,0);
    chk("R4 mcand low in window", mcand_clr_n, 0);
    chk("R5 mplr low with its pulse", mplr_clr_n, 0);
    chk("R5 acc high without its pulse", acc_clr_n, 1);
    cyc(0,0,0,1,0,0,0,0,0);
    chk("R5 acc low with its pulse", acc_clr_n, 0);
    chk("R5 mplr high without its pulse", mplr_clr_n, 1);
    cyc(0,0,1,0,0,0,0,0,0);                 // even release
    chk("R3 held through even cycle", mcand_clr_n, 0);
    cyc(0,0,0,0,0,0,0,0,0);
    chk("R3 released after even", mcand_clr_n, 1);
    cyc(0,1,0,0,0,0,0,0,0);                 // second odd, no request
    cyc(0,0,0,1,1,0,0,0,0);
    chk("R2 arming cleared after handoff", mcand_clr_n, 1);
    chk("R2 no acc clear outside window", acc_clr_n, 1);
    idle(DLY + 3);
    chk("R9 load gives no store pulse", n_st - s0, 0);
    chk("R9 load gives no store/clear pulse", n_sc - c0, 0);
  endtask

  task automatic t_no_xfer;
    cyc(0,0,0,0,0,1,0,0,0);                 // store without transfer done
    cyc(0,1,0,0,0,0,0,0,0);
    cyc(0,0,0,0,0,0,0,0,0);
    chk("R1 store without xfer sets nothing", mcand_clr_n, 1);
    idle(2);
  endtask

  task automatic t_store;
    int c0 = n_sc;
    cyc(0,0,0,0,0,1,0,1,0);
    cyc(0,1,0,0,0,0,0,0,0);
    cyc(0,0,0,1,0,0,0,0,0);
    chk("R4 store window", mcand_clr_n, 0);
    cyc(0,0,1,0,0,0,0,0,0);                 // falling acc gate, even strobe
    chk("R6 no pulse before even edge", store_end, 0);
    cyc(0,0,0,0,0,0,0,0,0);
    chk("R6 store pulse after even", store_end, 1);
    cyc(0,0,0,0,0,0,0,0,0);
    chk("R6 store pulse one cycle", store_end, 0);
    idle(DLY + 3);
    chk("R9 store gives no store/clear pulse", n_sc - c0, 0);
  endtask

  task automatic t_store_early_even;
    int s0 = n_st;
    cyc(0,0,0,0,0,1,0,1,0);
    cyc(0,0,1,0,0,0,0,0,0);                 // even before handoff
    cyc(0,0,0,0,0,0,0,0,0);
    chk("R6 pulse from early even", store_end, 1);
    chk("R6 no window yet", mcand_clr_n, 1);
    cyc(0,1,0,0,0,0,0,0,0);
    cyc(0,0,0,0,0,0,0,0,0);
    chk("R2 handoff after early even", mcand_clr_n, 0);
    cyc(0,0,1,0,0,0,0,0,0);
    cyc(0,0,0,0,0,0,0,0,0);
    chk("R6 window even gives no second pulse", store_end, 0);
    chk("R6 exactly one pulse", n_st - s0, 1);
    idle(2);
  endtask

  task automatic t_store_clr;
    int s0 = n_st, c0 = n_sc;
    cyc(0,0,0,0,0,0,1,1,0);                 // c1
    cyc(0,1,0,0,0,0,0,0,0);                 // c2
    cyc(0,0,0,1,0,0,0,0,0);                 // c3
    chk("R5 acc clear in store/clear window", acc_clr_n, 0);
    cyc(0,0,0,1,0,0,0,0,0);                 // c4
    cyc(0,0,0,0,0,0,0,0,0);                 // c5 falling gate
    cyc(0,0,0,0,0,0,1,1,0);                 // c6 second request
    cyc(0,1,0,0,0,0,0,0,0);                 // c7
    cyc(0,0,0,1,0,0,0,0,0);                 // c8
    cyc(0,0,0,0,0,0,0,0,0);                 // c9 fall while counting
    cyc(0,0,0,0,0,0,0,0,0);                 // c10
    cyc(0,0,0,0,0,0,0,0,0);                 // c11
    chk("R7 no pulse before delay", store_clr_end, 0);
    cyc(0,0,0,0,0,0,0,0,0);                 // c12
    chk("R7 pulse after delay", store_clr_end, 1);
    cyc(0,0,1,0,0,0,0,0,0);                 // c13
    chk("R7 pulse one cycle", store_clr_end, 0);
    idle(DLY + 4);
    chk("R8 retrigger ignored", n_sc - c0, 1);
    chk("R9 store/clear gives no store pulse", n_st - s0, 0);
    // Monostable re-arms once idle
    cyc(0,0,0,0,0,0,1,1,0);
    cyc(0,1,0,0,0,0,0,0,0);
    cyc(0,0,0,1,0,0,0,0,0);
    cyc(0,0,1,0,0,0,0,0,0);                 // fall at even release
    idle(DLY + 3);
    chk("R8 restarts after expiry", n_sc - c0, 2);
  endtask

  task automatic t_reset_mid;
    int s0 = n_st;
    cyc(0,0,0,0,0,1,0,1,0);
    cyc(0,1,0,0,0,0,0,0,0);
    cyc(0,0,0,0,0,0,0,0,0);
    chk("R4 window before reset", mcand_clr_n, 0);
    cyc(1,0,0,0,0,0,0,0,0);
    cyc(0,0,1,1,1,0,0,0,0);
    chk("R10 window dropped", mcand_clr_n, 1);
    chk("R10 acc stays high", acc_clr_n, 1);
    cyc(0,0,0,0,0,0,0,0,0);
    chk("R10 pending store dropped", n_st - s0, 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_load_mplr();
    t_no_xfer();
    t_store();
    t_store_early_even();
    t_store_clr();
    t_reset_mid();
    finish_run();
  end
endmodule